// File: doc/BRIEF.md
# Sequential Mean-of-Four Calculator

This block works out the arithmetic mean of four unsigned values held in a small internal register bank. A plain write port (enable, 2-bit address, data) fills the bank while the block is idle. Raising `start` begins a run. A control FSM clears an accumulator and preloads a down-counter with three. It then adds one register per clock, the counter value picking the register through a one-hot decode, from register 3 down to register 0. The sum and the divisor four go into a restoring shift-subtract divider. When the divider reports completion the FSM raises `done` and `mean` shows the truncated quotient.

The write port has no back-pressure. It never stalls: a write is taken on the clock edge where `wr_en` is high and the FSM is idle, and is dropped otherwise. `start` and `done` form a level handshake. `done` stays high while `start` is held, and the block goes back to idle one clock after `start` drops. The accumulator is two bits wider than the data, so the sum of four values cannot wrap.

Top module: `mean_calc`

## Requirements
- R1: An active-low asynchronous reset puts the FSM in idle with `done` low and clears all four bank registers, the accumulator and the counter, so a run right after reset gives `mean` = 0.
- R2: With `done` high, `mean` equals floor((R0+R1+R2+R3)/4), where Ri is the bank register at address i.
- R3: The sum is kept in DW+2 bits and never wraps, so four registers of all ones give `mean` = 2^DW-1.
- R4: Once `done` is high it stays high for as long as `start` stays high.
- R5: With `done` high and `start` low at a clock edge, `done` is low after that edge and a new run can begin.
- R6: A write presented while the FSM is not idle (accumulating, dividing or done) changes no bank register.
- R7: A write while idle stores `wr_data` in the register whose index equals `wr_addr` (0 to 3). Each of the four registers is added exactly once per run.
- R8: `done` rises on the 17th rising edge, counting as the first the edge that samples `start` high from idle (4 accumulate edges, 1 divider load edge, 10 divide steps, 1 completion edge, with the default DW=8).
- R9: At the end of division the remainder is smaller than the divisor, which makes the quotient the floor of the sum divided by four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request, held high until `done` has been seen |
| wr_en | input | 1 | Bank write enable (taken only while idle) |
| wr_addr | input | 2 | Bank register index |
| wr_data | input | DW | Value to store |
| done | output | 1 | Result valid, held while `start` is high |
| mean | output | DW | Mean of the four registers |

## Verification
The hardest case to reach is a write that lands while a run is in progress, because from the outside it looks the same as a write that was taken. The bench loads a known set, starts a run, and writes a different value to register 0 both during accumulation and while `done` is high. It then runs a second time with no writes in between. Both runs must return the mean of the original set, which is only true if the stray writes never reached the bank. An unsettled register select is tested with sets that put the full value in exactly one register, which makes each decode line show up on its own in the result.

// File: rtl/mean_pkg.sv
package mean_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACC    = 3'd1,
    ST_DLOAD  = 3'd2,
    ST_DWAIT  = 3'd3,
    ST_DONE   = 3'd4
  } mean_state_t;
endpackage

// File: rtl/mean_bank.sv
module mean_bank #(
  parameter int DW = 8,
  parameter int K  = 4,
  localparam int AW = $clog2(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_allow,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_sel,
  output logic [DW-1:0] rd_data
);
  logic [K-1:0]    rd_hot;
  logic [K*DW-1:0] bank_flat;
  logic [DW-1:0]   masked [K];

  for (genvar i = 0; i < K; i++) begin : g_slot
    logic [DW-1:0] slot_q;
    assign rd_hot[i] = (rd_sel == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (wr_allow && wr_en && wr_addr == AW'(i))
        slot_q <= wr_data;
    end
    assign bank_flat[i*DW +: DW] = slot_q;
    assign masked[i] = rd_hot[i] ? slot_q : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < K; i++) rd_data = rd_data | masked[i];
  end

  p_locked_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> $stable(bank_flat));
  p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hot));
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         fin
);
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] step_q;
  logic          busy_q, fin_q;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;
  logic          borrow;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_q};
    borrow  = trial[W+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (go) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
      step_q <= CW'(W);
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= borrow ? shifted[W-1:0] : trial[W-1:0];
      quo_q  <= {quo_q[W-2:0], ~borrow};
      step_q <= step_q - 1'b1;
      if (step_q == CW'(1)) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quotient = quo_q;
  assign fin      = fin_q;

  p_rem_below_divisor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < dvs_q));
  p_fin_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
endmodule

// File: rtl/mean_calc.sv
module mean_calc #(
  parameter int DW = 8,
  parameter int K  = 4,
  localparam int AW = $clog2(K),
  localparam int SW = DW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          done,
  output logic [DW-1:0] mean
);
  import mean_pkg::*;

  mean_state_t   state_q, state_d;
  logic [AW-1:0] cnt_q;
  logic [SW-1:0] acc_q;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] quo;
  logic          cnt_zero, div_go, div_fin, idle;

  assign idle     = (state_q == ST_IDLE);
  assign cnt_zero = (cnt_q == '0);
  assign div_go   = (state_q == ST_DLOAD);

  mean_bank #(.DW(DW), .K(K)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_allow(idle), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(cnt_q), .rd_data(rd_data)
  );

  seq_divider #(.W(SW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(acc_q),
    .divisor(SW'(K)), .quotient(quo), .fin(div_fin)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ACC;
      ST_ACC:   if (cnt_zero) state_d = ST_DLOAD;
      ST_DLOAD: state_d = ST_DWAIT;
      ST_DWAIT: if (div_fin) state_d = ST_DONE;
      ST_DONE:  if (!start) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        acc_q <= '0;
        cnt_q <= AW'(K - 1);
      end else if (state_q == ST_ACC) begin
        acc_q <= acc_q + SW'(rd_data);
        if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign done = (state_q == ST_DONE);
  assign mean = quo[DW-1:0];

  p_sum_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC) |=> (acc_q >= $past(acc_q)));
  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);
  p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  p_done_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> start);
endmodule

// File: tb/tb_mean_calc.sv
module tb_mean_calc;
  localparam int DW = 8;
  localparam int K  = 4;
  localparam int LAT = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic done;
  logic [DW-1:0] mean;

  int checks = 0;
  int errors = 0;
  int shadow [K];
  int cyc = 0;

  mean_calc #(.DW(DW), .K(K)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .mean(mean)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int v0, input int v1, input int v2, input int v3);
    wr(0, v0); wr(1, v1); wr(2, v2); wr(3, v3);
    shadow[0] = v0; shadow[1] = v1; shadow[2] = v2; shadow[3] = v3;
  endtask

  function automatic int expect_mean();
    int s = 0;
    for (int i = 0; i < K; i++) s += shadow[i];
    return s / K;
  endfunction

  // Runs one computation; optional stray write during the run (R6).
  task automatic run(input string tag, input bit stray, input bit chk_lat);
    int n = 0;
    @(negedge clk);
    start = 1'b1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
      if (stray && n == 2) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = ~DW'(shadow[0]);
      end else begin
        wr_en = 1'b0;
      end
    end
    wr_en = 1'b0;
    if (chk_lat) check({tag, " R8 latency"}, n, LAT);
    check({tag, " R2 mean"}, int'(mean), expect_mean());
    if (stray) begin
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = ~DW'(shadow[0]);
      @(negedge clk);
      wr_en = 1'b0;
    end
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check({tag, " R4 hold"}, int'(done), 1);
    end
    start = 1'b0;
    @(negedge clk);
    check({tag, " R5 release"}, int'(done), 0);
  endtask

  initial begin
    int seed = 7;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    shadow[0] = 0; shadow[1] = 0; shadow[2] = 0; shadow[3] = 0;
    run("R1 cleared bank", 1'b0, 1'b1);

    load(255, 255, 255, 255);
    run("R3 all ones", 1'b0, 1'b1);
    check("R3 max mean", int'(mean), 255);

    for (int r = 0; r < K; r++) begin
      load(r == 0 ? 200 : 0, r == 1 ? 200 : 0, r == 2 ? 200 : 0, r == 3 ? 200 : 0);
      run($sformatf("R7 single slot %0d", r), 1'b0, 1'b0);
    end

    for (int rem = 0; rem < K; rem++) begin
      load(10, 20, 30, 40 + rem);
      run($sformatf("R2 remainder %0d", rem), 1'b0, 1'b0);
    end

    load(12, 34, 56, 78);
    run("R6 stray write run", 1'b1, 1'b0);
    run("R6 rerun without writes", 1'b0, 1'b0);

    for (int t = 0; t < 40; t++) begin
      int v [K];
      for (int i = 0; i < K; i++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        v[i] = (seed >> 8) & 255;
      end
      load(v[0], v[1], v[2], v[3]);
      run($sformatf("R2 sweep %0d", t), 1'b0, 1'b1);
    end

    @(negedge clk);
    start = 1'b1;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check("R1 reset mid-run done", int'(done), 0);
    rst_n = 1'b1;
    shadow[0] = 0; shadow[1] = 0; shadow[2] = 0; shadow[3] = 0;
    run("R1 bank cleared after reset", 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule